// File: doc/BRIEF.md
# Snoop Filter Directory Array

This block holds the coherence directory for cache lines cached by processors on two front-side buses. The directory is split into affinity groups, one for each last-level cache, and each group is set-associative. A request carries a physical address, the requester's affinity group and an operation. Each operation reads the indexed set, searches every way of every group for the tag, and writes back the changed set. The block reports hit or miss, where the line sits and its stored state. When an allocation displaces a live line, it also reports that line's address and state, so the protocol engine can back-invalidate it.

Each entry stores a tag, an exclusive/modified flag and a two-bit bus ownership vector. Tracking is conservative: the directory only changes an entry when an update or invalidate names that entry. An entry can therefore still claim a line that a processor has quietly dropped. The victim way for an allocation comes from an external replacement selector. Group count, way count, set count, address width and line size are parameters, so a reduced array can be checked.

Top module: `snoopDir`

## Requirements
- R1: While reset is low, `busy` is 1 and no response is given. After reset is released, the array clears one set per clock and `busy` falls after exactly NUM_SET rising edges. From then on every lookup misses, including lookups of lines written before that reset.
- R2: Address bits below OFFS_W are ignored. The next log2(NUM_SET) bits select the set, and the bits above them are the tag. Two addresses that differ only in offset find the same entry. The same tag in another set misses.
- R3: A request is taken at a rising edge where `reqValid` is 1 and `busy` is 0. `rspValid` is 1 for exactly one cycle, after the second rising edge that follows. `busy` stays 1 from the edge that takes the request until the edge after the response. Every accepted request gets exactly one response.
- R4: The operation codes are 0 lookup, 1 update/add, 2 invalidate, and 3 acts as a lookup. A lookup compares the tag against every way of every group in the set. Its response gives the hit flag, group, way, flag and bus vector. Group, way, flag and bus vector are all 0 on a miss, and a lookup changes no entry.
- R5: Bus vector encoding is 00 invalid, 01 bus 0 owns, 10 bus 1 owns, 11 both buses share. On a hit, an update writes the requested flag and bus vector into the matching entry, whatever group holds it. The response reports the state as it was before the write.
- R6: An update that misses with a nonzero bus vector writes the new entry into the requester's group at `victimWay`. Other groups are left untouched. An update that misses with bus vector 00 writes nothing.
- R7: When an allocation overwrites a valid entry, `evictValid` is 1 in the same cycle as `rspValid`. `evictLine` then holds {victim tag, set index} and `evictEm`/`evictBus` hold the victim's state. Replacing an invalid entry gives no eviction.
- R8: An invalidate that hits sets the entry's bus vector to 00 and its flag to 0, and later lookups miss. An invalidate that misses changes nothing and reports a miss.
- R9: The combination flag=1 with bus vector 11 is never stored: such a write is stored as flag 0 with bus vector 11.
- R10: A tag is present at most once across all ways and groups of a set, so at most one way matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; starts the array clear |
| reqValid | input | 1 | Request strobe, taken when `busy` is 0 |
| reqOp | input | 2 | 0 lookup, 1 update/add, 2 invalidate, 3 lookup |
| reqAddr | input | ADDR_W | Physical address |
| reqGrp | input | GRP_W | Requester's affinity group |
| reqEm | input | 1 | Exclusive/modified flag to write |
| reqBus | input | 2 | Bus ownership vector to write |
| victimWay | input | WAY_W | Way to fill on an allocating miss |
| busy | output | 1 | Clearing or operation in progress |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | Tag found |
| rspGrp | output | GRP_W | Group of the matching entry |
| rspWay | output | WAY_W | Way of the matching entry |
| rspEm | output | 1 | Stored flag before the operation |
| rspBus | output | 2 | Stored bus vector before the operation |
| evictValid | output | 1 | A valid line was displaced |
| evictLine | output | ADDR_W-OFFS_W | Line address of the displaced entry |
| evictEm | output | 1 | Displaced entry's flag |
| evictBus | output | 2 | Displaced entry's bus vector |

## Verification
The embedded properties check four things on every cycle: that no more than one way matches a tag, that no write-back set holds the reserved flag/bus pair, that each accepted request gets a single-cycle response two edges later, and that an eviction never reports an invalid victim. Other behaviours need a sequence of operations and can only be shown by the bench's scenarios. These are where allocation lands and that other groups are untouched, that overwriting a shared line produces an eviction with the right address, that invalidates and data-less updates leave later lookups unchanged, and that a second reset wipes entries written earlier.

// File: rtl/snoopDirPkg.sv
package snoopDirPkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_UPDATE = 2'd1,
    OP_INVAL  = 2'd2,
    OP_PROBE  = 2'd3
  } dirOp_e;

  localparam logic [1:0] BUS_NONE = 2'b00;
  localparam logic [1:0] BUS_ZERO = 2'b01;
  localparam logic [1:0] BUS_ONE  = 2'b10;
  localparam logic [1:0] BUS_BOTH = 2'b11;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;  // capture request fields
    logic evalSet;   // read set, compare, build write-back image
    logic commit;    // write the image back
    logic clearRow;  // zero one set during init
  } dirStrobe_t;

endpackage

// File: rtl/snoopDirCtrl.sv
module snoopDirCtrl
  import snoopDirPkg::*;
#(
  parameter int NUM_SET = 16,
  parameter int IDX_W   = $clog2(NUM_SET)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output dirStrobe_t       strobe,
  output logic [IDX_W-1:0] clearIdx,
  output logic             busy,
  output logic             rspValid
);

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_LOOK, ST_WRITE} ctrlState_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SET - 1);

  ctrlState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_INIT;
      clearIdx <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          clearIdx <= clearIdx + 1'b1;
          if (clearIdx == LAST_IDX) state <= ST_IDLE;
        end
        ST_IDLE:  if (reqValid) state <= ST_LOOK;
        ST_LOOK:  state <= ST_WRITE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clearRow = (state == ST_INIT);
    strobe.latchReq = (state == ST_IDLE) && reqValid;
    strobe.evalSet  = (state == ST_LOOK);
    strobe.commit   = (state == ST_WRITE);
  end

  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_WRITE);

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);  // R3
  AST_ACCEPT_TO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchReq |-> ##2 rspValid);  // R3
  AST_NO_REINIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> (state != ST_INIT));  // R1

endmodule

// File: rtl/snoopDirData.sv
module snoopDirData
  import snoopDirPkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int NUM_WAY = 4,
  parameter int NUM_SET = 16,
  parameter int ADDR_W  = 38,
  parameter int OFFS_W  = 6,
  localparam int IDX_W  = $clog2(NUM_SET),
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int WAY_W  = (NUM_WAY > 1) ? $clog2(NUM_WAY) : 1,
  localparam int LINE_W = ADDR_W - OFFS_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        strobe,
  input  logic [IDX_W-1:0]  clearIdx,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [GRP_W-1:0]  reqGrp,
  input  logic              reqEm,
  input  logic [1:0]        reqBus,
  input  logic [WAY_W-1:0]  victimWay,
  output logic              hitQ,
  output logic [GRP_W-1:0]  hitGrpQ,
  output logic [WAY_W-1:0]  hitWayQ,
  output logic              oldEmQ,
  output logic [1:0]        oldBusQ,
  output logic              evictQ,
  output logic [LINE_W-1:0] evLineQ,
  output logic              evEmQ,
  output logic [1:0]        evBusQ
);

  localparam int ENT_N = NUM_GRP * NUM_WAY;
  localparam int ENT_W = TAG_W + 3;          // {tag, em, bus[1:0]}
  localparam int SET_W = ENT_N * ENT_W;

  // Directory storage: one word per set, all groups and ways side by side
  logic [SET_W-1:0] dirMem [NUM_SET];

  // Captured request
  dirOp_e           opQ;
  logic [TAG_W-1:0] tagQ;
  logic [IDX_W-1:0] idxQ;
  logic [GRP_W-1:0] grpQ;
  logic             emQ;
  logic [1:0]       busQ;
  logic [WAY_W-1:0] victQ;
  logic             unusedOffset;

  assign unusedOffset = ^reqAddr[OFFS_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.latchReq) begin
      opQ   <= dirOp_e'(reqOp);
      tagQ  <= reqAddr[ADDR_W-1 -: TAG_W];
      idxQ  <= reqAddr[OFFS_W +: IDX_W];
      grpQ  <= reqGrp;
      emQ   <= reqEm;
      busQ  <= reqBus;
      victQ <= victimWay;
    end
  end

  // Read and unpack the indexed set
  logic [SET_W-1:0] rdSet;
  logic [TAG_W-1:0] entTag [ENT_N];
  logic             entEm  [ENT_N];
  logic [1:0]       entBus [ENT_N];
  logic [ENT_N-1:0] hitVec;

  assign rdSet = dirMem[idxQ];

  for (genvar e = 0; e < ENT_N; e++) begin : g_ent
    assign entBus[e] = rdSet[e*ENT_W +: 2];
    assign entEm[e]  = rdSet[e*ENT_W + 2];
    assign entTag[e] = rdSet[e*ENT_W + 3 +: TAG_W];
    assign hitVec[e] = (entBus[e] != BUS_NONE) && (entTag[e] == tagQ);
  end

  // Locate the single match across every group
  logic             anyHit;
  int               hitPos;
  logic [GRP_W-1:0] hitGrp;
  logic [WAY_W-1:0] hitWay;

  assign anyHit = |hitVec;

  always_comb begin
    hitPos = 0;
    hitGrp = '0;
    hitWay = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int w = 0; w < NUM_WAY; w++) begin
        if (hitVec[g*NUM_WAY + w]) begin
          hitPos = g*NUM_WAY + w;
          hitGrp = GRP_W'(g);
          hitWay = WAY_W'(w);
        end
      end
    end
  end

  // Build the write-back image
  int               allocPos;
  logic             wrEm;
  logic             victimLive;
  logic [SET_W-1:0] newSet;
  logic             newWe;
  logic             newEvict;

  assign allocPos   = int'(grpQ) * NUM_WAY + int'(victQ);
  assign wrEm       = emQ && (busQ != BUS_BOTH);
  assign victimLive = (entBus[allocPos] != BUS_NONE);

  always_comb begin
    newSet   = rdSet;
    newWe    = 1'b0;
    newEvict = 1'b0;
    case (opQ)
      OP_UPDATE: begin
        if (anyHit) begin
          newSet[hitPos*ENT_W +: ENT_W] = {tagQ, wrEm, busQ};
          newWe = 1'b1;
        end else if (busQ != BUS_NONE) begin
          newSet[allocPos*ENT_W +: ENT_W] = {tagQ, wrEm, busQ};
          newWe    = 1'b1;
          newEvict = victimLive;
        end
      end
      OP_INVAL: begin
        if (anyHit) begin
          newSet[hitPos*ENT_W +: ENT_W] = {tagQ, 1'b0, BUS_NONE};
          newWe = 1'b1;
        end
      end
      default: ;
    endcase
  end

  logic [SET_W-1:0] pendSet;
  logic             pendWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWe <= 1'b0;
      evictQ <= 1'b0;
      hitQ   <= 1'b0;
    end else if (strobe.evalSet) begin
      pendWe <= newWe;
      evictQ <= newEvict;
      hitQ   <= anyHit;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.evalSet) begin
      pendSet <= newSet;
      hitGrpQ <= hitGrp;
      hitWayQ <= hitWay;
      oldEmQ  <= anyHit ? entEm[hitPos]  : 1'b0;
      oldBusQ <= anyHit ? entBus[hitPos] : BUS_NONE;
      evLineQ <= {entTag[allocPos], idxQ};
      evEmQ   <= entEm[allocPos];
      evBusQ  <= entBus[allocPos];
    end
  end

  // Storage write port: clear during init, write-back otherwise
  always_ff @(posedge clk) begin
    if (strobe.clearRow) begin
      dirMem[clearIdx] <= '0;
    end else if (strobe.commit && pendWe) begin
      dirMem[idxQ] <= pendSet;
    end
  end

  logic resvInPend;

  always_comb begin
    resvInPend = 1'b0;
    for (int e = 0; e < ENT_N; e++) begin
      if (pendSet[e*ENT_W + 2] && (pendSet[e*ENT_W +: 2] == BUS_BOTH)) resvInPend = 1'b1;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evalSet |-> ($countones(hitVec) <= 1));  // R10
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && pendWe) |-> !resvInPend);  // R9
  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchReq && (reqOp == OP_UPDATE)) |-> (int'(victimWay) < NUM_WAY));  // R6
  AST_EVICT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && evictQ) |-> (evBusQ != BUS_NONE));  // R7

endmodule

// File: rtl/snoopDir.sv
module snoopDir
  import snoopDirPkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int NUM_WAY = 4,
  parameter int NUM_SET = 16,
  parameter int ADDR_W  = 38,
  parameter int OFFS_W  = 6,
  localparam int IDX_W  = $clog2(NUM_SET),
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int WAY_W  = (NUM_WAY > 1) ? $clog2(NUM_WAY) : 1,
  localparam int LINE_W = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [GRP_W-1:0]  reqGrp,
  input  logic              reqEm,
  input  logic [1:0]        reqBus,
  input  logic [WAY_W-1:0]  victimWay,
  output logic              busy,
  output logic              rspValid,
  output logic              rspHit,
  output logic [GRP_W-1:0]  rspGrp,
  output logic [WAY_W-1:0]  rspWay,
  output logic              rspEm,
  output logic [1:0]        rspBus,
  output logic              evictValid,
  output logic [LINE_W-1:0] evictLine,
  output logic              evictEm,
  output logic [1:0]        evictBus
);

  dirStrobe_t       strobe;
  logic [IDX_W-1:0] clearIdx;
  logic             evictPend;

  snoopDirCtrl #(
    .NUM_SET (NUM_SET),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .clearIdx (clearIdx),
    .busy     (busy),
    .rspValid (rspValid)
  );

  snoopDirData #(
    .NUM_GRP (NUM_GRP),
    .NUM_WAY (NUM_WAY),
    .NUM_SET (NUM_SET),
    .ADDR_W  (ADDR_W),
    .OFFS_W  (OFFS_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .clearIdx  (clearIdx),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .reqGrp    (reqGrp),
    .reqEm     (reqEm),
    .reqBus    (reqBus),
    .victimWay (victimWay),
    .hitQ      (rspHit),
    .hitGrpQ   (rspGrp),
    .hitWayQ   (rspWay),
    .oldEmQ    (rspEm),
    .oldBusQ   (rspBus),
    .evictQ    (evictPend),
    .evLineQ   (evictLine),
    .evEmQ     (evictEm),
    .evBusQ    (evictBus)
  );

  assign evictValid = rspValid && evictPend;

endmodule

// File: tb/snoopDir_bench.sv
module snoopDir_bench;

  localparam int NUM_GRP = 4;
  localparam int NUM_WAY = 4;
  localparam int NUM_SET = 16;
  localparam int ADDR_W  = 38;
  localparam int OFFS_W  = 6;
  localparam int IDX_W   = 4;
  localparam int GRP_W   = 2;
  localparam int WAY_W   = 2;
  localparam int LINE_W  = ADDR_W - OFFS_W;
  localparam int TAG_W   = LINE_W - IDX_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [1:0]        reqOp;
  logic [ADDR_W-1:0] reqAddr;
  logic [GRP_W-1:0]  reqGrp;
  logic              reqEm;
  logic [1:0]        reqBus;
  logic [WAY_W-1:0]  victimWay;
  logic              busy, rspValid, rspHit, rspEm, evictValid, evictEm;
  logic [GRP_W-1:0]  rspGrp;
  logic [WAY_W-1:0]  rspWay;
  logic [1:0]        rspBus, evictBus;
  logic [LINE_W-1:0] evictLine;

  always #2 clk = ~clk;

  snoopDir u_snoopDir (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqGrp(reqGrp), .reqEm(reqEm), .reqBus(reqBus), .victimWay(victimWay),
    .busy(busy), .rspValid(rspValid), .rspHit(rspHit), .rspGrp(rspGrp), .rspWay(rspWay),
    .rspEm(rspEm), .rspBus(rspBus), .evictValid(evictValid), .evictLine(evictLine),
    .evictEm(evictEm), .evictBus(evictBus)
  );

  typedef struct {
    string             req;
    logic              hit;
    logic [GRP_W-1:0]  grp;
    logic [WAY_W-1:0]  way;
    logic              em;
    logic [1:0]        bus;
    logic              ev;
    logic [LINE_W-1:0] evLine;
    logic              evEm;
    logic [1:0]        evBus;
  } expItem_t;

  expItem_t expQ[$];

  logic [TAG_W-1:0] mTag [NUM_SET][NUM_GRP][NUM_WAY];
  logic             mEm  [NUM_SET][NUM_GRP][NUM_WAY];
  logic [1:0]       mBus [NUM_SET][NUM_GRP][NUM_WAY];

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int s = 0; s < NUM_SET; s++)
      for (int g = 0; g < NUM_GRP; g++)
        for (int w = 0; w < NUM_WAY; w++) begin
          mTag[s][g][w] = '0;
          mEm[s][g][w]  = 1'b0;
          mBus[s][g][w] = 2'b00;
        end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input logic [TAG_W-1:0] t,
                                               input int idx, input logic [5:0] offs);
    return {t, IDX_W'(idx), offs};
  endfunction

  // Reference model from the requirements
  task automatic predict(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                         input int grp, input logic em, input logic [1:0] bus,
                         input int vict, input string req, output expItem_t e);
    int idx;
    int hg, hw;
    logic [TAG_W-1:0] tg;
    idx = int'(addr[OFFS_W +: IDX_W]);
    tg  = addr[ADDR_W-1 -: TAG_W];
    e.req = req; e.hit = 0; e.grp = '0; e.way = '0; e.em = 0; e.bus = 2'b00;
    e.ev = 0; e.evLine = '0; e.evEm = 0; e.evBus = 2'b00;
    hg = 0; hw = 0;
    for (int g = 0; g < NUM_GRP; g++)
      for (int w = 0; w < NUM_WAY; w++)
        if (mBus[idx][g][w] != 2'b00 && mTag[idx][g][w] == tg) begin
          e.hit = 1; hg = g; hw = w;
          e.grp = GRP_W'(g); e.way = WAY_W'(w);
          e.em = mEm[idx][g][w]; e.bus = mBus[idx][g][w];
        end
    if (op == 2'd1) begin
      if (e.hit) begin
        mEm[idx][hg][hw]  = em && (bus != 2'b11);
        mBus[idx][hg][hw] = bus;
      end else if (bus != 2'b00) begin
        if (mBus[idx][grp][vict] != 2'b00) begin
          e.ev = 1;
          e.evLine = {mTag[idx][grp][vict], IDX_W'(idx)};
          e.evEm = mEm[idx][grp][vict];
          e.evBus = mBus[idx][grp][vict];
        end
        mTag[idx][grp][vict] = tg;
        mEm[idx][grp][vict]  = em && (bus != 2'b11);
        mBus[idx][grp][vict] = bus;
      end
    end else if (op == 2'd2 && e.hit) begin
      mEm[idx][hg][hw]  = 1'b0;
      mBus[idx][hg][hw] = 2'b00;
    end
  endtask

  // Driver: predicts, queues the expectation, drives one request
  task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                       input int grp, input logic em, input logic [1:0] bus,
                       input int vict, input string req);
    expItem_t e;
    predict(op, addr, grp, em, bus, vict, req, e);
    expQ.push_back(e);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqGrp = GRP_W'(grp);
    reqEm = em; reqBus = bus; victimWay = WAY_W'(vict);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy && !rspValid, "R3", "busy without response after accept", {busy, rspValid}, 2'b10);
    @(negedge clk);
    chk(busy && rspValid, "R3", "response cycle", {busy, rspValid}, 2'b11);
    @(negedge clk);
    chk(!busy && !rspValid, "R3", "idle after response", {busy, rspValid}, 2'b00);
  endtask

  // Monitor: pops expectations as responses appear
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        chk(0, "R3", "unexpected response", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(rspHit == e.hit, e.req, "hit", rspHit, e.hit);
        chk(rspGrp == e.grp && rspWay == e.way, e.req, "group/way",
            {rspGrp, rspWay}, {e.grp, e.way});
        chk(rspEm == e.em && rspBus == e.bus, e.req, "stored state",
            {rspEm, rspBus}, {e.em, e.bus});
        chk(evictValid == e.ev, e.req, "evictValid", evictValid, e.ev);
        if (e.ev)
          chk(evictLine == e.evLine && evictEm == e.evEm && evictBus == e.evBus, e.req,
              "evicted line/state", {evictLine, evictEm, evictBus}, {e.evLine, e.evEm, e.evBus});
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  task automatic doReset(input string req);
    int cnt;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && !rspValid && !evictValid, req, "state during reset",
        {busy, rspValid, evictValid}, 3'b100);
    rstN = 1'b1;
    modelClear();
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (busy && cnt < 1000);
    chk(cnt == NUM_SET, req, "edges until busy falls", cnt, NUM_SET);
  endtask

  localparam logic [TAG_W-1:0] TA = 'h123;
  localparam logic [TAG_W-1:0] TB = 'h456;
  localparam logic [TAG_W-1:0] TC = 'h789;
  localparam logic [TAG_W-1:0] TD = 'hABC;
  localparam logic [TAG_W-1:0] TE = 'hFEDCBA9;

  initial begin
    reqValid = 0; reqOp = 0; reqAddr = '0; reqGrp = '0;
    reqEm = 0; reqBus = 0; victimWay = '0;
    modelClear();
    doReset("R1");

    issue(2'd0, mkAddr(TA, 3, 6'h00), 0, 0, 2'b00, 0, "R1");   // empty: miss
    issue(2'd1, mkAddr(TA, 3, 6'h00), 1, 1, 2'b01, 2, "R6");   // allocate grp1 way2
    issue(2'd0, mkAddr(TA, 3, 6'h2a), 0, 0, 2'b00, 0, "R2");   // offset ignored: hit
    issue(2'd0, mkAddr(TA, 4, 6'h00), 0, 0, 2'b00, 0, "R2");   // other set: miss
    issue(2'd1, mkAddr(TA, 3, 6'h11), 3, 1, 2'b11, 0, "R5");   // hit from grp3, reserved pair
    issue(2'd0, mkAddr(TA, 3, 6'h00), 0, 0, 2'b00, 0, "R9");   // stored as em0 bus11
    issue(2'd1, mkAddr(TB, 3, 6'h00), 1, 0, 2'b10, 2, "R7");   // evicts A
    issue(2'd0, mkAddr(TA, 3, 6'h00), 0, 0, 2'b00, 0, "R7");   // A gone
    issue(2'd0, mkAddr(TB, 3, 6'h00), 0, 0, 2'b00, 0, "R4");   // B hit grp1 way2
    issue(2'd1, mkAddr(TC, 3, 6'h00), 0, 1, 2'b01, 2, "R6");   // grp0 way2: no evict
    issue(2'd0, mkAddr(TB, 3, 6'h00), 0, 0, 2'b00, 0, "R6");   // B untouched
    issue(2'd1, mkAddr(TD, 3, 6'h00), 2, 1, 2'b00, 0, "R6");   // bus 00 miss: no write
    issue(2'd0, mkAddr(TD, 3, 6'h00), 0, 0, 2'b00, 0, "R6");   // still miss
    issue(2'd2, mkAddr(TB, 3, 6'h00), 0, 0, 2'b00, 0, "R8");   // invalidate hit
    issue(2'd0, mkAddr(TB, 3, 6'h00), 0, 0, 2'b00, 0, "R8");   // now miss
    issue(2'd2, mkAddr(TD, 3, 6'h00), 0, 0, 2'b00, 0, "R8");   // invalidate miss
    issue(2'd0, mkAddr(TC, 3, 6'h00), 0, 0, 2'b00, 0, "R8");   // C intact
    issue(2'd1, mkAddr(TD, 3, 6'h00), 1, 1, 2'b10, 2, "R7");   // fills invalid slot
    issue(2'd3, mkAddr(TC, 3, 6'h3f), 0, 0, 2'b00, 0, "R4");   // code 3 acts as lookup
    issue(2'd0, mkAddr(TD, 3, 6'h00), 0, 0, 2'b00, 0, "R10");  // single match
    issue(2'd1, mkAddr(TE, 15, 6'h00), 3, 1, 2'b01, 3, "R6");  // top set, top group/way
    issue(2'd0, mkAddr(TE, 15, 6'h3f), 0, 0, 2'b00, 0, "R2");
    issue(2'd1, mkAddr(TE, 15, 6'h00), 0, 0, 2'b11, 0, "R5");  // hit: to shared
    issue(2'd1, mkAddr(TA, 15, 6'h00), 3, 0, 2'b01, 3, "R7");  // evicts shared E

    doReset("R1");
    issue(2'd0, mkAddr(TC, 3, 6'h00), 0, 0, 2'b00, 0, "R1");
    issue(2'd0, mkAddr(TA, 15, 6'h00), 0, 0, 2'b00, 0, "R1");
    issue(2'd0, mkAddr(TD, 3, 6'h00), 0, 0, 2'b00, 0, "R1");

    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R3", "responses outstanding", expQ.size(), 0);
    done = 1;
    finishRun();
  end

endmodule